// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

This unit is one execute-stage datapath slice that rearranges a 32-bit operand in one of three ways. It can exchange the two bytes inside each halfword, reverse the order of all four bytes, or exchange the upper and lower halfwords. A caller presents the operand together with an 11-bit extended operation code and a valid strobe. One clock later the unit returns the registered result with a one-cycle done pulse and an updated set of four condition flags: zero, sign, carry and overflow.

Each variant derives carry from its own test for zero content. The full byte reverse sets carry when any result byte is zero. The halfword exchange sets carry when either result halfword is zero. The byte swap within halfwords looks only at the lowest result byte. Overflow is always cleared. If the operation code is not one of the three known values, the unit reports an illegal operation and leaves its result and flags as they were. Register-file access, instruction fetch and all other instructions are handled elsewhere.

Top module: `swap_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is result 0, all four flags 0, `done_o` 0 and `illegal_o` 0, whatever the other inputs are.
- R2: Operation code 11'b01101000010 selects the byte swap within halfwords: result bits 7:0 = source 15:8, 15:8 = source 7:0, 23:16 = source 31:24, 31:24 = source 23:16.
- R3: Operation code 11'b01101000000 selects the full byte reverse: result byte 0 = source byte 3, byte 1 = byte 2, byte 2 = byte 1, byte 3 = byte 0.
- R4: Operation code 11'b01101000100 selects the halfword exchange: result 31:16 = source 15:0 and result 15:0 = source 31:16.
- R5: After any legal operation, `flag_z_o` is 1 exactly when the result is zero, and `flag_s_o` equals result bit 31.
- R6: After any legal operation, `flag_ov_o` is 0.
- R7: For the full byte reverse, `flag_cy_o` is 1 exactly when at least one of the four result bytes is 0x00.
- R8: For the halfword exchange, `flag_cy_o` is 1 exactly when result 15:0 or result 31:16 is zero.
- R9: For the byte swap within halfwords, `flag_cy_o` is 1 exactly when result bits 7:0 are zero.
- R10: The result and flags of a strobe sampled at a rising edge appear after that edge, together with `done_o` high for that one cycle. Strobes on consecutive edges give consecutive results. In a cycle after an edge where `valid_i` was low, `done_o` is 0 and the result and flags hold.
- R11: A strobe whose operation code is none of the three codes gives `done_o` and `illegal_o` high for one cycle, and the result and all flags keep their previous values. `illegal_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 32 | Source operand |
| xop_i | input | 11 | Extended operation code |
| done_o | output | 1 | One-cycle pulse, one clock after a strobe |
| illegal_o | output | 1 | High with `done_o` when the operation code was unrecognised |
| result_o | output | 32 | Registered rearranged operand |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |
| flag_cy_o | output | 1 | Carry flag, rule depends on operation |
| flag_ov_o | output | 1 | Overflow flag, cleared by every legal operation |

## Verification
The bench runs each legal operation on every word built from the byte values 0x00, 0x01, 0x7F, 0x80 and 0xFF in all positions, then on pseudo-random words, so that each byte position is zero or has its top bit set on its own. A carry rule taken from the wrong variant shows up at once. Testing only the low byte for the full reverse misses words whose only zero byte sits elsewhere, and a halfword test applied to the byte swap misses a lone zero low byte. The bench also sweeps all 2048 operation codes with strobes back to back. A decoder that accepts a near-miss code, or that writes the result on an illegal strobe, changes values the bench expects to hold. Idle cycles catch a done pulse that stretches, and a reset applied while a strobe is asserted catches state loaded during reset.

// File: rtl/swap_pkg.sv
// Shared constants and types for the swap unit.
// Assumes an 11-bit extended operation code; the three codes are fixed.
package swap_pkg;

    localparam int XOP_W = 11;

    localparam logic [XOP_W-1:0] XOP_BYTE_HALF = 11'b01101000010;
    localparam logic [XOP_W-1:0] XOP_BYTE_WORD = 11'b01101000000;
    localparam logic [XOP_W-1:0] XOP_HALF_SWAP = 11'b01101000100;

    typedef enum logic [1:0] {
        SW_NONE      = 2'd0,
        SW_BYTE_HALF = 2'd1,
        SW_BYTE_WORD = 2'd2,
        SW_HALF_SWAP = 2'd3
    } swap_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
        logic ov;
    } swap_flags_t;

endpackage

// File: rtl/swap_decode.sv
// Turns the extended operation code into an internal operation.
// Purely combinational. Any code outside the three known values maps to
// SW_NONE and raises illegal_o.
module swap_decode
    import swap_pkg::*;
(
    input  logic [XOP_W-1:0] xop_i,
    output swap_op_e         op_o,
    output logic             illegal_o
);

    // Match the code against the three known values.
    always_comb begin
        case (xop_i)
            XOP_BYTE_HALF: op_o = SW_BYTE_HALF;
            XOP_BYTE_WORD: op_o = SW_BYTE_WORD;
            XOP_HALF_SWAP: op_o = SW_HALF_SWAP;
            default:       op_o = SW_NONE;
        endcase
    end

    // Flag codes that no operation claimed.
    always_comb illegal_o = (op_o == SW_NONE);

endmodule

// File: rtl/swap_lanes.sv
// Byte-lane routing for the three rearrangements.
// Assumes DATA_W is a multiple of 16. Combinational. Outputs zero for SW_NONE.
module swap_lanes
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src_i,
    input  swap_op_e          op_i,
    output logic [DATA_W-1:0] res_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] byte_half_w;
    logic [DATA_W-1:0] byte_word_w;
    logic [DATA_W-1:0] half_swap_w;

    // One routing slice per destination byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign byte_half_w[b*8 +: 8] = src_i[(b ^ 1)*8 +: 8];
        assign byte_word_w[b*8 +: 8] = src_i[(NBYTES-1-b)*8 +: 8];
    end

    assign half_swap_w = {src_i[HALF_W-1:0], src_i[DATA_W-1:HALF_W]};

    // Choose the routed word for the selected operation.
    always_comb begin
        case (op_i)
            SW_BYTE_HALF: res_o = byte_half_w;
            SW_BYTE_WORD: res_o = byte_word_w;
            SW_HALF_SWAP: res_o = half_swap_w;
            default:      res_o = '0;
        endcase
    end

endmodule

// File: rtl/swap_flags.sv
// Condition-flag generation from a rearranged result.
// Combinational. Carry follows a rule that depends on the operation.
// Overflow is always produced as zero.
module swap_flags
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  swap_op_e          op_i,
    output swap_flags_t       flags_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int HBYTES = NBYTES / 2;

    logic [NBYTES-1:0] byte_zero;
    logic              lo_half_zero;
    logic              hi_half_zero;

    // Per-byte zero detectors.
    for (genvar b = 0; b < NBYTES; b++) begin : g_bz
        assign byte_zero[b] = (res_i[b*8 +: 8] == 8'h00);
    end

    // Halfword zero from the byte detectors.
    always_comb begin
        lo_half_zero = &byte_zero[HBYTES-1:0];
        hi_half_zero = &byte_zero[NBYTES-1:HBYTES];
    end

    // Assemble the flag set for the chosen operation.
    always_comb begin
        flags_o.z  = &byte_zero;
        flags_o.s  = res_i[DATA_W-1];
        flags_o.ov = 1'b0;
        case (op_i)
            SW_BYTE_HALF: flags_o.cy = byte_zero[0];
            SW_BYTE_WORD: flags_o.cy = |byte_zero;
            SW_HALF_SWAP: flags_o.cy = lo_half_zero | hi_half_zero;
            default:      flags_o.cy = 1'b0;
        endcase
    end

endmodule

// File: rtl/swap_unit.sv
// Top level of the swap unit: decode, lane routing, flags and output registers.
// Assumes one strobe per clock at most. Synchronous active-low reset.
// Illegal strobes update only done/illegal.
module swap_unit
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [XOP_W-1:0]  xop_i,
    output logic              done_o,
    output logic              illegal_o,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_z_o,
    output logic              flag_s_o,
    output logic              flag_cy_o,
    output logic              flag_ov_o
);

    swap_op_e          op_c;
    logic              illegal_c;
    logic [DATA_W-1:0] res_c;
    swap_flags_t       flags_c;
    swap_flags_t       flags_q;

    swap_decode u_decode (
        .xop_i     (xop_i),
        .op_o      (op_c),
        .illegal_o (illegal_c)
    );

    swap_lanes #(.DATA_W(DATA_W)) u_lanes (
        .src_i (src_i),
        .op_i  (op_c),
        .res_o (res_c)
    );

    swap_flags #(.DATA_W(DATA_W)) u_flags (
        .res_i   (res_c),
        .op_i    (op_c),
        .flags_o (flags_c)
    );

    // Register the strobe status, and the result and flags on legal strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            result_o  <= '0;
            flags_q   <= '0;
        end else begin
            done_o    <= valid_i;
            illegal_o <= valid_i & illegal_c;
            if (valid_i && !illegal_c) begin
                result_o <= res_c;
                flags_q  <= flags_c;
            end
        end
    end

    // Break the flag register out to ports.
    always_comb begin
        flag_z_o  = flags_q.z;
        flag_s_o  = flags_q.s;
        flag_cy_o = flags_q.cy;
        flag_ov_o = flags_q.ov;
    end

endmodule

// File: rtl/swap_unit_chk.sv
// Checker for swap_unit port behaviour. It is bound to every instance.
module swap_unit_chk
    import swap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [DATA_W-1:0] src_i,
    input logic [XOP_W-1:0]  xop_i,
    input logic              done_o,
    input logic              illegal_o,
    input logic [DATA_W-1:0] result_o,
    input logic              flag_z_o,
    input logic              flag_s_o,
    input logic              flag_cy_o,
    input logic              flag_ov_o
);

    localparam int HALF_W = DATA_W / 2;

    logic known_op;
    assign known_op = (xop_i == XOP_BYTE_HALF) || (xop_i == XOP_BYTE_WORD) ||
                      (xop_i == XOP_HALF_SWAP);

    assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);
    assert_idle_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o && $stable(result_o) && $stable(flag_cy_o) && $stable(flag_z_o));
    assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !known_op) |=> illegal_o && $stable(result_o) && $stable(flag_cy_o)
                                   && $stable(flag_s_o) && $stable(flag_z_o));
    assert_illegal_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> done_o);
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> !flag_ov_o);
    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (flag_z_o == (result_o == '0)));
    assert_sign_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (flag_s_o == result_o[DATA_W-1]));
    assert_half_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && xop_i == XOP_HALF_SWAP) |=>
            (result_o == {$past(src_i[HALF_W-1:0]), $past(src_i[DATA_W-1:HALF_W])}));
    assert_half_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && xop_i == XOP_HALF_SWAP) |=>
            (flag_cy_o == ((result_o[HALF_W-1:0] == '0) || (result_o[DATA_W-1:HALF_W] == '0))));
    assert_byte_half_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && xop_i == XOP_BYTE_HALF) |=> (flag_cy_o == (result_o[7:0] == 8'h00)));

endmodule

bind swap_unit swap_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .src_i     (src_i),
    .xop_i     (xop_i),
    .done_o    (done_o),
    .illegal_o (illegal_o),
    .result_o  (result_o),
    .flag_z_o  (flag_z_o),
    .flag_s_o  (flag_s_o),
    .flag_cy_o (flag_cy_o),
    .flag_ov_o (flag_ov_o)
);

// File: tb/swap_unit_bench.sv
`timescale 1ns/1ps
module swap_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] src_i = '0;
    logic [10:0] xop_i = '0;
    logic        done_o, illegal_o, flag_z_o, flag_s_o, flag_cy_o, flag_ov_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_res = '0;
    logic        exp_z = 1'b0, exp_s = 1'b0, exp_cy = 1'b0, exp_ov = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #2.5 clk = ~clk;

    swap_unit u_swap_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .src_i(src_i), .xop_i(xop_i),
        .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o),
        .flag_z_o(flag_z_o), .flag_s_o(flag_s_o), .flag_cy_o(flag_cy_o), .flag_ov_o(flag_ov_o)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    function automatic logic [7:0] pick(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h7F;
            3: return 8'h80;
            default: return 8'hFF;
        endcase
    endfunction

    // Drive one strobe (entered at a falling edge), then check the outputs one cycle later.
    task automatic run_op(input logic [31:0] s, input logic [10:0] x);
        logic legal;
        string tag;
        legal = 1'b1;
        tag = "R11";
        case (x)
            11'b01101000010: begin
                exp_res = ((s & 32'h00FF00FF) << 8) | ((s >> 8) & 32'h00FF00FF);
                exp_cy  = (exp_res % 256) == 0;                       // R9
                tag = "R2/R9";
            end
            11'b01101000000: begin
                exp_res = (s << 24) | ((s << 8) & 32'h00FF0000) |
                          ((s >> 8) & 32'h0000FF00) | (s >> 24);
                exp_cy  = ((exp_res - 32'h01010101) & ~exp_res & 32'h80808080) != 0; // R7
                tag = "R3/R7";
            end
            11'b01101000100: begin
                exp_res = (s << 16) | (s >> 16);
                exp_cy  = ((exp_res % 65536) == 0) || ((exp_res / 65536) == 0);     // R8
                tag = "R4/R8";
            end
            default: legal = 1'b0;
        endcase
        if (legal) begin
            exp_z  = (exp_res == 0);
            exp_s  = exp_res >= 32'h8000_0000;
            exp_ov = 1'b0;
        end
        valid_i = 1'b1;
        src_i   = s;
        xop_i   = x;
        @(negedge clk);
        valid_i = 1'b0;
        check(done_o == 1'b1, "R10 done", {31'd0, done_o}, 32'd1);
        check(illegal_o == !legal, "R11 illegal", {31'd0, illegal_o}, {31'd0, !legal});
        check(result_o == exp_res, tag, result_o, exp_res);
        check(flag_z_o == exp_z, "R5 zero", {31'd0, flag_z_o}, {31'd0, exp_z});
        check(flag_s_o == exp_s, "R5 sign", {31'd0, flag_s_o}, {31'd0, exp_s});
        check(flag_cy_o == exp_cy, tag, {31'd0, flag_cy_o}, {31'd0, exp_cy});
        check(flag_ov_o == exp_ov, "R6 overflow", {31'd0, flag_ov_o}, {31'd0, exp_ov});
    endtask

    // Idle cycle: no done, state held (R10).
    task automatic idle_check();
        @(negedge clk);
        check(done_o == 1'b0, "R10 idle done", {31'd0, done_o}, 32'd0);
        check(result_o == exp_res, "R10 idle hold", result_o, exp_res);
        check(flag_cy_o == exp_cy, "R10 idle carry", {31'd0, flag_cy_o}, {31'd0, exp_cy});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset with a strobe present must load nothing.
        valid_i = 1'b1;
        src_i   = 32'h1234_5678;
        xop_i   = 11'b01101000100;
        repeat (3) @(negedge clk);
        check(result_o == 32'd0, "R1 result", result_o, 32'd0);
        check(done_o == 1'b0, "R1 done", {31'd0, done_o}, 32'd0);
        check({flag_z_o, flag_s_o, flag_cy_o, flag_ov_o, illegal_o} == 5'b0, "R1 flags",
              {27'd0, flag_z_o, flag_s_o, flag_cy_o, flag_ov_o, illegal_o}, 32'd0);
        valid_i = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        idle_check();

        // Sweep of structured byte patterns across all three operations.
        for (int op = 0; op < 3; op++) begin
            for (int w = 0; w < 625; w++) begin
                logic [10:0] x;
                x = (op == 0) ? 11'b01101000010 : (op == 1) ? 11'b01101000000 : 11'b01101000100;
                run_op({pick(w / 125), pick((w / 25) % 5), pick((w / 5) % 5), pick(w % 5)}, x);
            end
            idle_check();
        end

        // Pseudo-random operands.
        for (int i = 0; i < 300; i++) begin
            lfsr = step(lfsr);
            run_op(lfsr, (i % 3 == 0) ? 11'b01101000010 :
                         (i % 3 == 1) ? 11'b01101000000 : 11'b01101000100);
        end
        idle_check();

        // Every operation code, back to back (R11 holds on the illegal ones).
        for (int c = 0; c < 2048; c++) begin
            lfsr = step(lfsr);
            run_op(lfsr, c[10:0]);
            if (c % 256 == 0) idle_check();
        end
        idle_check();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule